// File: doc/BRIEF.md
# CAN Receive Message Queue with Register Window

This block holds received CAN frames until software has read them. The receive path offers one frame per cycle, with a queue index, an identifier, a timestamp, a label word and four data words. Each queue stores accepted frames in arrival order. Software reads the oldest unread frame through a small window of word registers. It then releases that frame by writing a fixed command byte to a pointer-control register.

Each queue keeps a count of unread frames and derives empty and full status from it. It has a sticky lost-frame flag and a sticky interrupt request flag, and the interrupt flag drives an output pin. Several queues sit side by side. Each queue has its own configuration word (enable, interrupt enable, per-frame mode and a count threshold) and its own window. A queue is chosen by the upper address bits or by the push index.

Top module: `can_rx_fifo_top`

## Requirements
- R1: After reset every queue reads CFG (offset 0) as 0, STAT (offset 1) as 0x00000001 (empty only), PTRCTL (offset 2) as 0, and every irq output is 0.
- R2: An accepted push stores the frame behind all unread frames. The window shows the oldest unread frame at these offsets: ID low half at 3, ID high half at 4, timestamp at 5, label at 6, data words 0 to 3 at offsets 7 to 10.
- R3: A register write to offset 2 whose low byte is 0xFF releases the head frame and lowers the unread count by one. A write to offset 2 with any other low byte changes nothing.
- R4: A release write is ignored while the queue is disabled or its unread count is zero.
- R5: A push to a full queue is dropped and sets the lost flag. The count and the head frame stay the same.
- R6: CFG bit 0 is the enable bit. Writing it to 0 forces the unread count to zero and resets both pointers in the same cycle. A push to a disabled queue is dropped and does not set the lost flag.
- R7: STAT bit 0 is empty (count is 0) and bit 1 is full (count equals DEPTH). STAT bits 13:8 hold the 6-bit unread count, which never exceeds DEPTH.
- R8: With CFG bit 1 (interrupt enable) set and CFG bit 2 clear, the interrupt flag (STAT bit 3, also the queue's irq pin) is set by an accepted push that makes the count equal CFG bits 13:8.
- R9: With CFG bits 1 and 2 both set, every accepted push sets the interrupt flag.
- R10: The lost flag (STAT bit 2) and the interrupt flag stay set until a STAT write carries 0 in that bit. A STAT write that carries 1 leaves the flag unchanged. If a set event and a clear write land in the same cycle, the flag ends up set.
- R11: A push and a release accepted in the same cycle leave the unread count unchanged, and the new frame queues behind the rest.
- R12: Address bits above bit 3 select the queue for register access, and push_sel selects it for pushes. Activity on one queue never changes another queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Receive path offers a frame this cycle |
| push_sel | input | QSEL_W | Target queue of the pushed frame |
| push_id | input | 32 | Frame identifier |
| push_ts | input | 16 | Frame timestamp |
| push_label | input | 16 | Pointer/label word |
| push_data | input | 128 | Four data words, word 0 in bits 31:0 |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | QSEL_W+4 | Write address: queue select and word offset |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | QSEL_W+4 | Read address, decoded combinationally |
| reg_rdata | output | 32 | Read data for reg_raddr |
| irq | output | NUM_Q | Interrupt request flag of each queue |

## Verification
The bench builds the block with DEPTH=4 and two queues. A depth of four means a few pushes fill a queue, so the full, lost-frame and wrap-around pointer cases come up often during the random run. They do not rely on the directed steps alone. Two queues are enough to show that pushes, releases and flag clears aimed at one queue leave the other unchanged. The random run also reprograms the configuration at times, which covers disabling a queue mid-stream and threshold values both below and above the depth.

// File: rtl/can_rxq_pkg.sv
`timescale 1ns/1ps
package can_rxq_pkg;

    localparam int CNT_W  = 6;
    localparam int OFF_W  = 4;
    localparam int WORD_W = 32;
    localparam int NDATA  = 4;

    localparam logic [7:0] RELEASE_CODE = 8'hFF;

    typedef enum logic [OFF_W-1:0] {
        WIN_CFG    = 4'd0,
        WIN_STAT   = 4'd1,
        WIN_PTRCTL = 4'd2,
        WIN_IDLO   = 4'd3,
        WIN_IDHI   = 4'd4,
        WIN_TS     = 4'd5,
        WIN_LABEL  = 4'd6,
        WIN_D0     = 4'd7,
        WIN_D1     = 4'd8,
        WIN_D2     = 4'd9,
        WIN_D3     = 4'd10
    } win_off_e;

    typedef struct packed {
        logic [31:0]                   id;
        logic [15:0]                   ts;
        logic [15:0]                   label;
        logic [NDATA-1:0][WORD_W-1:0]  data;
    } rx_frame_t;

    typedef struct packed {
        logic [CNT_W-1:0] thr;
        logic             permsg;
        logic             ie;
        logic             en;
    } rxq_cfg_t;

    function automatic rxq_cfg_t cfg_from_word(input logic [WORD_W-1:0] w);
        rxq_cfg_t c;
        c.en     = w[0];
        c.ie     = w[1];
        c.permsg = w[2];
        c.thr    = w[8 +: CNT_W];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] cfg_to_word(input rxq_cfg_t c);
        return {18'b0, c.thr, 5'b0, c.permsg, c.ie, c.en};
    endfunction

    function automatic logic [WORD_W-1:0] stat_word(input logic empty, input logic full,
                                                    input logic lost, input logic irqf,
                                                    input logic [CNT_W-1:0] cnt);
        return {18'b0, cnt, 4'b0, irqf, lost, full, empty};
    endfunction

    function automatic logic [WORD_W-1:0] frame_word(input rx_frame_t f,
                                                     input logic [OFF_W-1:0] off);
        logic [WORD_W-1:0] w;
        case (off)
            WIN_IDLO:  w = {16'b0, f.id[15:0]};
            WIN_IDHI:  w = {16'b0, f.id[31:16]};
            WIN_TS:    w = {16'b0, f.ts};
            WIN_LABEL: w = {16'b0, f.label};
            WIN_D0:    w = f.data[0];
            WIN_D1:    w = f.data[1];
            WIN_D2:    w = f.data[2];
            WIN_D3:    w = f.data[3];
            default:   w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store
    import can_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  rx_frame_t        wframe,
    input  logic [PTR_W-1:0] raddr,
    output rx_frame_t        rframe
);

    rx_frame_t slots [DEPTH];

    always_ff @(posedge clk) begin
        if (we) slots[waddr] <= wframe;
    end

    assign rframe = slots[raddr];

endmodule

// File: rtl/rxq_ctrl.sv
`timescale 1ns/1ps
module rxq_ctrl
    import can_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_req,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [WORD_W-1:0] wr_data,
    output logic              push_ok,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic [PTR_W-1:0]  rd_ptr,
    output rxq_cfg_t          cfg,
    output logic [CNT_W-1:0]  count,
    output logic              empty,
    output logic              full,
    output logic              lost,
    output logic              irq_flag
);

    rxq_cfg_t         cfg_q, cfg_nxt;
    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    logic [PTR_W-1:0] wp_q, rp_q;
    logic             lost_q, irq_q;
    logic             cfg_wr, stat_wr, rel_req, rel_ok, drop, live, irq_set;
    logic             clr_lost, clr_irq;

    function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        cfg_wr   = wr_en && (wr_off == WIN_CFG);
        stat_wr  = wr_en && (wr_off == WIN_STAT);
        rel_req  = wr_en && (wr_off == WIN_PTRCTL) && (wr_data[7:0] == RELEASE_CODE);
        cfg_nxt  = cfg_wr ? cfg_from_word(wr_data) : cfg_q;
        live     = cfg_q.en & cfg_nxt.en;
        empty    = (cnt_q == '0);
        full     = (cnt_q == CNT_W'(DEPTH));
        push_ok  = push_req & live & ~full;
        drop     = push_req & live & full;
        rel_ok   = rel_req & live & ~empty;
        cnt_nxt  = cnt_q + CNT_W'(push_ok) - CNT_W'(rel_ok);
        irq_set  = cfg_q.ie & push_ok & (cfg_q.permsg | (cnt_nxt == cfg_q.thr));
        clr_lost = stat_wr & ~wr_data[2];
        clr_irq  = stat_wr & ~wr_data[3];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            cnt_q  <= '0;
            wp_q   <= '0;
            rp_q   <= '0;
            lost_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            cfg_q  <= cfg_nxt;
            lost_q <= drop | (lost_q & ~clr_lost);
            irq_q  <= irq_set | (irq_q & ~clr_irq);
            if (!cfg_nxt.en) begin
                cnt_q <= '0;
                wp_q  <= '0;
                rp_q  <= '0;
            end else begin
                cnt_q <= cnt_nxt;
                if (push_ok) wp_q <= adv(wp_q);
                if (rel_ok)  rp_q <= adv(rp_q);
            end
        end
    end

    assign wr_ptr   = wp_q;
    assign rd_ptr   = rp_q;
    assign cfg      = cfg_q;
    assign count    = cnt_q;
    assign lost     = lost_q;
    assign irq_flag = irq_q;

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH));

    assert_disable_empties_R6: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.en |=> (cnt_q == '0));

    assert_empty_release_R4: assert property (@(posedge clk) disable iff (rst)
        (rel_req && empty && !push_req) |=> (cnt_q == '0));

    assert_full_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (push_req && full && !rel_req && cfg_nxt.en) |=> (cnt_q == $past(cnt_q)));

    assert_lost_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (lost_q && !clr_lost) |=> lost_q);

    assert_pair_keeps_count_R11: assert property (@(posedge clk) disable iff (rst)
        (push_ok && rel_ok) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/rxq_lane.sv
`timescale 1ns/1ps
module rxq_lane
    import can_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_req,
    input  rx_frame_t         push_frame,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [WORD_W-1:0] rd_data,
    output logic              irq
);

    logic             push_ok, empty, full, lost, irq_flag;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    rxq_cfg_t         cfg;
    rx_frame_t        head;

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .push_req (push_req),
        .wr_en    (wr_en),
        .wr_off   (wr_off),
        .wr_data  (wr_data),
        .push_ok  (push_ok),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .cfg      (cfg),
        .count    (count),
        .empty    (empty),
        .full     (full),
        .lost     (lost),
        .irq_flag (irq_flag)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .we     (push_ok),
        .waddr  (wr_ptr),
        .wframe (push_frame),
        .raddr  (rd_ptr),
        .rframe (head)
    );

    always_comb begin
        case (rd_off)
            WIN_CFG:    rd_data = cfg_to_word(cfg);
            WIN_STAT:   rd_data = stat_word(empty, full, lost, irq_flag, count);
            WIN_PTRCTL: rd_data = '0;
            default:    rd_data = frame_word(head, rd_off);
        endcase
    end

    assign irq = irq_flag;

endmodule

// File: rtl/can_rx_fifo_top.sv
`timescale 1ns/1ps
module can_rx_fifo_top
    import can_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int NUM_Q = 2,
    localparam int QSEL_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    localparam int ADDR_W = QSEL_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               push_valid,
    input  logic [QSEL_W-1:0]  push_sel,
    input  logic [31:0]        push_id,
    input  logic [15:0]        push_ts,
    input  logic [15:0]        push_label,
    input  logic [127:0]       push_data,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_waddr,
    input  logic [31:0]        reg_wdata,
    input  logic [ADDR_W-1:0]  reg_raddr,
    output logic [31:0]        reg_rdata,
    output logic [NUM_Q-1:0]   irq
);

    rx_frame_t         frame_in;
    logic [WORD_W-1:0] lane_rdata [NUM_Q];
    logic [QSEL_W-1:0] wq, rq;

    assign frame_in.id    = push_id;
    assign frame_in.ts    = push_ts;
    assign frame_in.label = push_label;
    assign frame_in.data  = push_data;

    assign wq = reg_waddr[ADDR_W-1:OFF_W];
    assign rq = reg_raddr[ADDR_W-1:OFF_W];

    for (genvar q = 0; q < NUM_Q; q++) begin : g_lane
        rxq_lane #(.DEPTH(DEPTH)) u_lane (
            .clk        (clk),
            .rst        (rst),
            .push_req   (push_valid && (push_sel == QSEL_W'(q))),
            .push_frame (frame_in),
            .wr_en      (reg_wr && (wq == QSEL_W'(q))),
            .wr_off     (reg_waddr[OFF_W-1:0]),
            .wr_data    (reg_wdata),
            .rd_off     (reg_raddr[OFF_W-1:0]),
            .rd_data    (lane_rdata[q]),
            .irq        (irq[q])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int q = 0; q < NUM_Q; q++) begin
            if (rq == QSEL_W'(q)) reg_rdata = lane_rdata[q];
        end
    end

endmodule

// File: tb/sim_can_rx_fifo_top.sv
`timescale 1ns/1ps
module sim_can_rx_fifo_top;

    localparam int D = 4;
    localparam int NQ = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         push_valid = 1'b0;
    logic [0:0]   push_sel = '0;
    logic [31:0]  push_id = '0;
    logic [15:0]  push_ts = '0;
    logic [15:0]  push_label = '0;
    logic [127:0] push_data = '0;
    logic         reg_wr = 1'b0;
    logic [4:0]   reg_waddr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [4:0]   reg_raddr = '0;
    logic [31:0]  reg_rdata;
    logic [1:0]   irq;

    can_rx_fifo_top #(.DEPTH(D), .NUM_Q(NQ)) u0 (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_sel(push_sel),
        .push_id(push_id), .push_ts(push_ts), .push_label(push_label),
        .push_data(push_data), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model: frame = {id, ts, label, data3..data0}
    logic [191:0] m_buf [NQ][D];
    int m_head [NQ];
    int m_cnt  [NQ];
    bit m_en [NQ], m_ie [NQ], m_pm [NQ], m_lost [NQ], m_irq [NQ];
    int m_thr [NQ];

    function automatic logic [31:0] exp_word(input logic [191:0] f, input int off);
        case (off)
            3: return {16'b0, f[175:160]};
            4: return {16'b0, f[191:176]};
            5: return {16'b0, f[159:144]};
            6: return {16'b0, f[143:128]};
            7: return f[31:0];
            8: return f[63:32];
            9: return f[95:64];
            10: return f[127:96];
            default: return 32'b0;
        endcase
    endfunction

    function automatic logic [31:0] exp_stat(input int q);
        return {18'b0, 6'(m_cnt[q]), 4'b0, m_irq[q], m_lost[q], m_cnt[q] == D, m_cnt[q] == 0};
    endfunction

    function automatic logic [31:0] exp_cfg(input int q);
        return {18'b0, 6'(m_thr[q]), 5'b0, m_pm[q], m_ie[q], m_en[q]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        for (int q = 0; q < NQ; q++) begin
            bit wq, cfgw, en_n, live, pq, isfull, pok, drop, rok, setirq, stw;
            int off;
            wq     = reg_wr && (reg_waddr[4] == q[0]);
            off    = int'(reg_waddr[3:0]);
            cfgw   = wq && off == 0;
            stw    = wq && off == 1;
            en_n   = cfgw ? reg_wdata[0] : m_en[q];
            live   = m_en[q] && en_n;
            pq     = push_valid && (push_sel == q[0]);
            isfull = (m_cnt[q] == D);
            pok    = pq && live && !isfull;
            drop   = pq && live && isfull;
            rok    = wq && off == 2 && reg_wdata[7:0] == 8'hFF && live && m_cnt[q] > 0;
            if (rok) begin
                m_head[q] = (m_head[q] + 1) % D;
                m_cnt[q]--;
            end
            if (pok) begin
                m_buf[q][(m_head[q] + m_cnt[q]) % D] = {push_id, push_ts, push_label, push_data};
                m_cnt[q]++;
            end
            setirq = m_ie[q] && pok && (m_pm[q] || m_cnt[q] == m_thr[q]);
            m_lost[q] = drop || (m_lost[q] && !(stw && !reg_wdata[2]));
            m_irq[q]  = setirq || (m_irq[q] && !(stw && !reg_wdata[3]));
            if (!en_n) begin
                m_cnt[q] = 0;
                m_head[q] = 0;
            end
            if (cfgw) begin
                m_en[q]  = reg_wdata[0];
                m_ie[q]  = reg_wdata[1];
                m_pm[q]  = reg_wdata[2];
                m_thr[q] = int'(reg_wdata[13:8]);
            end
        end
    endtask

    task automatic step(input bit pv, input int psel, input bit wr, input int waddr,
                        input logic [31:0] wdata);
        push_valid = pv;
        push_sel   = 1'(psel);
        push_id    = $urandom;
        push_ts    = 16'($urandom);
        push_label = 16'($urandom);
        push_data  = {$urandom, $urandom, $urandom, $urandom};
        reg_wr     = wr;
        reg_waddr  = 5'(waddr);
        reg_wdata  = wdata;
        @(posedge clk);
        model_step();
        @(negedge clk);
        push_valid = 1'b0;
        reg_wr     = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_raddr = 5'(a);
        #0.05;
        d = reg_rdata;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] d;
        for (int q = 0; q < NQ; q++) begin
            rd(q * 16 + 1, d);
            chk({tag, " STAT"}, d, exp_stat(q));
            rd(q * 16 + 0, d);
            chk({tag, " CFG"}, d, exp_cfg(q));
            chk({tag, " irq pin"}, 32'(irq[q]), 32'(m_irq[q]));
            if (m_cnt[q] > 0) begin
                for (int off = 3; off <= 10; off++) begin
                    rd(q * 16 + off, d);
                    chk({tag, " head word"}, d, exp_word(m_buf[q][m_head[q]], off));
                end
            end
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        for (int q = 0; q < NQ; q++) begin
            m_head[q] = 0; m_cnt[q] = 0; m_en[q] = 0; m_ie[q] = 0;
            m_pm[q] = 0; m_lost[q] = 0; m_irq[q] = 0; m_thr[q] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check_all("R1");
        rd(2, d);  chk("R1 PTRCTL q0", d, 32'h0);
        rd(18, d); chk("R1 PTRCTL q1", d, 32'h0);
        rd(1, d);  chk("R1 STAT literal", d, 32'h1);

        // R6 push while disabled is dropped without lost
        step(1, 0, 0, 0, 0);
        check_all("R6 disabled push");

        // enable q0 threshold 3, q1 per-message
        step(0, 0, 1, 0, 32'h0303);
        step(0, 0, 1, 16, 32'h0007);
        check_all("R8 cfg");

        // R8 threshold
        step(1, 0, 0, 0, 0); check_all("R2 push1");
        step(1, 0, 0, 0, 0); check_all("R8 below thr");
        chk("R8 irq low before threshold", 32'(irq[0]), 32'h0);
        step(1, 0, 0, 0, 0); check_all("R8 at thr");
        chk("R8 irq set at threshold", 32'(irq[0]), 32'h1);

        // R7 full, R5 drop
        step(1, 0, 0, 0, 0); check_all("R7 full");
        rd(1, d); chk("R7 full bit", d & 32'h3, 32'h2);
        step(1, 0, 0, 0, 0); check_all("R5 drop when full");
        rd(1, d); chk("R5 lost bit", (d >> 2) & 32'h1, 32'h1);

        // R3 wrong code ignored, right code releases
        step(0, 0, 1, 2, 32'h7F); check_all("R3 wrong code");
        step(0, 0, 1, 2, 32'hFF); check_all("R3 release");
        rd(1, d); chk("R3 count after release", (d >> 8) & 32'h3F, 32'd3);

        // R11 push and release together
        step(1, 0, 1, 2, 32'hFF); check_all("R11 pair");

        // R10 write 1 keeps, write 0 clears
        step(0, 0, 1, 1, 32'hC); check_all("R10 keep");
        step(0, 0, 1, 1, 32'h0); check_all("R10 clear");
        chk("R10 irq pin cleared", 32'(irq[0]), 32'h0);

        // R9 / R12 on q1
        step(1, 1, 0, 0, 0); check_all("R9 per-message");
        chk("R12 q0 irq untouched", 32'(irq[0]), 32'h0);
        step(0, 0, 1, 18, 32'hFF); check_all("R12 release q1");
        step(0, 0, 1, 18, 32'hFF); check_all("R4 release on empty");
        rd(17, d); chk("R4 empty q1", d & 32'h1, 32'h1);

        // R6 disable q0, R4 release while disabled
        step(0, 0, 1, 0, 32'h0); check_all("R6 disable");
        rd(1, d); chk("R6 count zero", (d >> 8) & 32'h3F, 32'd0);
        step(1, 0, 1, 2, 32'hFF); check_all("R4 disabled release");

        // random phase
        step(0, 0, 1, 0, 32'h0203);
        for (int i = 0; i < 1500; i++) begin
            int r, q;
            logic [31:0] w;
            r = int'($urandom % 100);
            q = int'($urandom % 2);
            if (r < 35)      step($urandom % 2 == 0, int'($urandom % 2), 1, q * 16 + 2, 32'hFF);
            else if (r < 40) step($urandom % 2 == 0, int'($urandom % 2), 1, q * 16 + 2, 32'($urandom % 255));
            else if (r < 45) step($urandom % 2 == 0, int'($urandom % 2), 1, q * 16 + 1, 32'($urandom) & 32'hC);
            else if (r < 48) begin
                w = {18'b0, 6'($urandom % 6), 5'b0, 1'($urandom), 1'($urandom), 1'($urandom % 8 != 0)};
                step($urandom % 2 == 0, int'($urandom % 2), 1, q * 16, w);
            end
            else             step($urandom % 3 != 0, int'($urandom % 2), 0, 0, 0);
            check_all("R2 R3 R7 random");
        end

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule